// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus, placed in front of a 256-byte memory that starts out filled with FFh. It works on the system clock. SCL and SDA are oversampled through two-flop synchronisers, and bus events are found by comparing consecutive synchronised samples. The block recognises START and STOP conditions and decodes a one-byte header. That header holds a 4-bit type code, three bits that must match the strap inputs, and a read/write flag. The block acknowledges on the ninth clock. The open-drain SDA line is driven through a single pull-low enable.

Writes are collected in a 16-byte page staging buffer. They reach the array only when the master closes the transfer with STOP. A second type code addresses a one-time protect latch. Once the latch is set, the lower half of the array rejects every later write. Reads can be current, random or sequential. The internal address counter follows different rules after reads and after writes, so a current read always knows where to continue.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset every array location reads FFh, and the SDA pull-low output is inactive.
- R2: A header is acknowledged only when bits 7..4 are 1010 (array) or 0110 (protect latch, write only) and bits 3..1 equal strap_i[2:0]; bit 0 is 1 for read and 0 for write. On any other header the slave gives no acknowledge and ignores the bus until the next START or STOP.
- R3: The slave pulls SDA low during the ninth clock after an accepted header, after the word-address byte, and after each write data byte.
- R4: A byte write (header, word address, data, STOP) stores the data at the word address.
- R5: In a write, bits 7..4 of the location stay fixed and bits 3..0 advance by one per data byte, wrapping within the 16-byte page. More than 16 bytes overwrite the bytes staged earlier.
- R6: A write that is ended by a repeated START instead of STOP changes no array location.
- R7: A random read (write header, word address, repeated START, read header) returns the byte at that word address.
- R8: During a read, a low acknowledge from the master makes the slave send the byte at the next address. The address wraps from FFh to 00h.
- R9: After a read, the current address is the last address read plus one. After a write, it is the last address written.
- R10: A high acknowledge from the master ends a read. The slave then releases SDA and drives nothing until the next START or STOP.
- R11: A write command to the protect latch, with at least one data byte and a STOP, permanently blocks writes to locations 00h..7Fh. Writes to 80h..FFh still take effect.
- R12: The SDA drive changes only after a falling SCL edge or a bus condition. Input bits are taken on rising SCL edges.
- R13: A START followed by a STOP in the middle of a header aborts the command. The next full command is served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Device-select straps compared with header bits 3..1 |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low (open drain) |

## Verification
A wrong internal state shows up at the ports within one byte time. It appears either as an acknowledge bit at the wrong level on the next ninth clock, or as a data byte that differs from the bench's memory model on the next read. Address counter faults, such as a wrong increment rule, a missing page wrap or a wrong post-write position, appear on the first current or sequential read that follows. Staging and commit faults appear on the random read right after the write. A stuck SDA drive appears as a corrupted START or STOP, or as low bits in a byte the slave should not be driving.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;

    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_PROT  = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WADR,
        ST_WDAT,
        ST_ACK,
        ST_RD,
        ST_RACK,
        ST_HOLD
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_up,
    output logic scl_dn,
    output logic cond_start,
    output logic cond_stop
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_s      = scl_sh_q[STAGES-1];
    assign sda_s      = sda_sh_q[STAGES-1];
    assign scl_up     = scl_s & ~scl_p_q;
    assign scl_dn     = ~scl_s & scl_p_q;
    assign cond_start = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign cond_stop  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/twi_store.sv
module twi_store #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stg_we,
    input  logic [PAGE_W-1:0]        stg_idx,
    input  logic [7:0]               stg_byte,
    input  logic                     stg_clr,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic                     prot_set,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE_LEN = 1 << PAGE_W;
    localparam int PG_W     = ADDR_W - PAGE_W;

    logic [7:0]          mem_q   [DEPTH];
    logic [7:0]          stage_q [PAGE_LEN];
    logic [PAGE_LEN-1:0] mask_q;
    logic                prot_q;
    logic                page_ok;

    // lower half is the protectable region: page MSB clear
    assign page_ok = !(prot_q && !commit_page[PG_W-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < PAGE_LEN; k++) stage_q[k] <= 8'h00;
            mask_q <= '0;
        end else if (stg_clr || commit) begin
            mask_q <= '0;
        end else if (stg_we) begin
            stage_q[stg_idx] <= stg_byte;
            mask_q[stg_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
        end else if (commit && page_ok) begin
            for (int k = 0; k < PAGE_LEN; k++) begin
                if (mask_q[k]) mem_q[{commit_page, PAGE_W'(k)}] <= stage_q[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        prot_q <= 1'b0;
        else if (prot_set) prot_q <= 1'b1;
    end

    assign rd_data = mem_q[rd_addr];

    // R11: the protect latch never clears once set
    p_prot_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q |=> prot_q);

    // R6: an abandoned transfer leaves nothing staged
    p_stage_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stg_clr |=> (mask_q == '0));

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
    import twi_eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sda_s,
    input  logic                     scl_up,
    input  logic                     scl_dn,
    input  logic                     cond_start,
    input  logic                     cond_stop,
    input  logic [2:0]               strap_i,
    input  logic [7:0]               rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     stg_we,
    output logic [PAGE_W-1:0]        stg_idx,
    output logic [7:0]               stg_byte,
    output logic                     stg_clr,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] commit_page,
    output logic                     prot_set,
    output logic                     sda_pull
);
    typedef struct packed {
        twi_state_e        state;
        twi_state_e        after;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic              pull;
        logic              to_prot;
        logic              first;
        logic              wr_pend;
        logic              prot_arm;
        logic              go;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        logic [ADDR_W-1:0] loc;
        logic              hit;
        d        = q;
        stg_we   = 1'b0;
        stg_clr  = 1'b0;
        commit   = 1'b0;
        prot_set = 1'b0;
        loc      = q.first ? q.addr
                           : {q.addr[ADDR_W-1:PAGE_W], q.addr[PAGE_W-1:0] + 1'b1};
        hit      = (q.sh[3:1] == strap_i);
        if (cond_start) begin
            d.state    = ST_HDR;
            d.cnt      = 4'd0;
            d.pull     = 1'b0;
            d.wr_pend  = 1'b0;
            d.prot_arm = 1'b0;
            stg_clr    = 1'b1;
        end else if (cond_stop) begin
            commit     = q.wr_pend;
            prot_set   = q.prot_arm;
            d.state    = ST_IDLE;
            d.pull     = 1'b0;
            d.wr_pend  = 1'b0;
            d.prot_arm = 1'b0;
        end else begin
            unique case (q.state)
                ST_HDR, ST_WADR, ST_WDAT: begin
                    if (scl_up && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (scl_dn && q.cnt == 4'd8) begin
                        d.state = ST_ACK;
                        d.pull  = 1'b1;
                        if (q.state == ST_HDR) begin
                            d.first = 1'b1;
                            if (hit && q.sh[7:4] == TYPE_ARRAY) begin
                                d.to_prot = 1'b0;
                                d.after   = q.sh[0] ? ST_RD : ST_WADR;
                            end else if (hit && q.sh[7:4] == TYPE_PROT && !q.sh[0]) begin
                                d.to_prot = 1'b1;
                                d.after   = ST_WADR;
                            end else begin
                                d.state = ST_HOLD;
                                d.pull  = 1'b0;
                            end
                        end else if (q.state == ST_WADR) begin
                            if (!q.to_prot) d.addr = q.sh;
                            d.first = 1'b1;
                            d.after = ST_WDAT;
                        end else begin
                            d.after = ST_WDAT;
                            if (q.to_prot) begin
                                d.prot_arm = 1'b1;
                            end else begin
                                stg_we    = 1'b1;
                                d.addr    = loc;
                                d.first   = 1'b0;
                                d.wr_pend = 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_dn) begin
                        d.state = q.after;
                        d.cnt   = 4'd0;
                        if (q.after == ST_RD) begin
                            d.sh   = rd_data;
                            d.pull = ~rd_data[7];
                        end else begin
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_dn) begin
                        if (q.cnt == 4'd7) begin
                            d.pull  = 1'b0;
                            d.state = ST_RACK;
                            d.go    = 1'b0;
                            d.addr  = q.addr + 1'b1;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.pull = ~q.sh[6];
                            d.cnt  = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_up) d.go = ~sda_s;
                    if (scl_dn) begin
                        if (q.go) begin
                            d.state = ST_RD;
                            d.cnt   = 4'd0;
                            d.sh    = rd_data;
                            d.pull  = ~rd_data[7];
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
        stg_idx  = loc[PAGE_W-1:0];
        stg_byte = q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.after    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_addr     = q.addr;
    assign commit_page = q.addr[ADDR_W-1:PAGE_W];
    assign sda_pull    = q.pull;

    // R12: drive only moves after a falling SCL or a bus condition
    p_drive_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pull) |-> $past(scl_dn || cond_start || cond_stop));

    // R10: idle and ignoring states never hold SDA low
    p_quiet_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE || q.state == ST_HOLD) |-> !q.pull);

    // R3: an acknowledge slot always pulls the line
    p_ack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ACK) |-> q.pull);

    // R8: a transmitted byte has eight bit slots
    p_rd_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD) |-> (q.cnt <= 4'd7));

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic              sda_s, scl_up, scl_dn, cond_start, cond_stop;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data, stg_byte;
    logic              stg_we, stg_clr, commit, prot_set;
    logic [PAGE_W-1:0] stg_idx;
    logic [PG_W-1:0]   commit_page;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_up(scl_up), .scl_dn(scl_dn),
        .cond_start(cond_start), .cond_stop(cond_stop)
    );

    twi_proto_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_up(scl_up),
        .scl_dn(scl_dn), .cond_start(cond_start), .cond_stop(cond_stop),
        .strap_i(strap_i), .rd_data(rd_data), .rd_addr(rd_addr),
        .stg_we(stg_we), .stg_idx(stg_idx), .stg_byte(stg_byte),
        .stg_clr(stg_clr), .commit(commit), .commit_page(commit_page),
        .prot_set(prot_set), .sda_pull(sda_pull_o)
    );

    twi_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_idx(stg_idx),
        .stg_byte(stg_byte), .stg_clr(stg_clr), .commit(commit),
        .commit_page(commit_page), .prot_set(prot_set),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
    localparam int Q = 10;
    localparam logic [7:0] HW = 8'hAA;  // 1010 101 0
    localparam logic [7:0] HR = 8'hAB;
    localparam logic [15:0] WVEC [6] = '{16'h005A, 16'h01A5, 16'h7F3C,
                                         16'h80C3, 16'hFF01, 16'h4200};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull;
    wire  sda_bus = m_sda & ~sda_pull;
    int   n_chk = 0, n_bad = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    twi_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_i(3'b101), .sda_pull_o(sda_pull)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; hold(); m_scl = 1'b1; hold();
        m_sda = 1'b0; hold(); m_scl = 1'b0; hold();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; hold(); m_scl = 1'b1; hold(); m_sda = 1'b1; hold();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b; hold(); m_scl = 1'b1; hold();
        seen = sda_bus; hold(); m_scl = 1'b0; hold();
    endtask

    task automatic send(input logic [7:0] b, output logic ack_hi);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, ack_hi);
    endtask

    task automatic recv(input logic ack_low, output logic [7:0] b);
        logic s;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(!ack_low, s);
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] a);
        logic k;
        m_start();
        send(HW, k); chk("R3 hdr ack", k, 0);
        send(a, k);  chk("R3 word ack", k, 0);
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] v);
        logic k;
        set_addr(a);
        send(v, k); chk("R3 data ack", k, 0);
        m_stop();
    endtask

    task automatic read_hdr();
        logic k;
        m_start();
        send(HR, k); chk("R2 read hdr ack", k, 0);
    endtask

    initial begin
        logic       k;
        logic [7:0] v;
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hold();
        chk("R1 pull idle", sda_pull, 0);

        set_addr(8'h33); read_hdr(); recv(1'b0, v); m_stop();
        chk("R1 blank FF", v, 8'hFF);

        // R2 strap and type mismatch
        m_start(); send(8'hA2, k); chk("R2 wrong strap nack", k, 1);
        send(8'h00, k); chk("R2 ignored after mismatch", k, 1); m_stop();
        m_start(); send(8'hEA, k); chk("R2 wrong type nack", k, 1); m_stop();

        // R4 R7 table of byte writes and random reads
        foreach (WVEC[i]) begin
            byte_write(WVEC[i][15:8], WVEC[i][7:0]);
            model[WVEC[i][15:8]] = WVEC[i][7:0];
        end
        foreach (WVEC[i]) begin
            set_addr(WVEC[i][15:8]); read_hdr(); recv(1'b0, v); m_stop();
            chk("R4 R7 readback", v, model[WVEC[i][15:8]]);
        end

        // R5 page write past 16 bytes, wrap in page
        set_addr(8'h2E);
        for (int i = 0; i < 18; i++) begin
            send(8'(8'hC0 + i), k); chk("R5 page ack", k, 0);
            model[{4'h2, 4'(4'hE + i)}] = 8'(8'hC0 + i);
        end
        m_stop();
        // R9 current read after write: last written
        read_hdr(); recv(1'b0, v); m_stop();
        chk("R9 cur after write", v, model[8'h2F]);
        read_hdr(); recv(1'b0, v); m_stop();
        chk("R9 cur after read", v, model[8'h30]);
        set_addr(8'h20); read_hdr();
        for (int i = 0; i < 16; i++) begin
            recv(i < 15, v);
            chk("R5 R8 page contents", v, model[8'h20 + i]);
        end
        m_stop();

        // R6 no STOP, R10 slave silent after nack
        set_addr(8'h50); send(8'h77, k);
        read_hdr(); recv(1'b0, v);
        chk("R6 not committed", v, 8'hFF);
        recv(1'b0, v);
        chk("R10 silent after nack", v, 8'hFF);
        m_stop();
        set_addr(8'h50); read_hdr(); recv(1'b0, v); m_stop();
        chk("R6 location unchanged", v, 8'hFF);

        // R8 sequential wrap FF -> 00
        set_addr(8'hFE); read_hdr();
        recv(1'b1, v); chk("R8 seq FE", v, model[8'hFE]);
        recv(1'b1, v); chk("R8 seq FF", v, model[8'hFF]);
        recv(1'b0, v); chk("R8 seq wrap 00", v, model[8'h00]);
        m_stop();

        // R13 abort mid header
        m_start(); clk_bit(1'b1, k); clk_bit(1'b0, k); clk_bit(1'b1, k);
        m_stop();
        chk("R13 released after abort", sda_pull, 0);
        set_addr(8'h01); read_hdr(); recv(1'b0, v); m_stop();
        chk("R13 next command ok", v, model[8'h01]);

        // R11 protect latch
        m_start(); send(8'h6B, k); chk("R11 prot read nack", k, 1); m_stop();
        m_start(); send(8'h6A, k); chk("R11 prot hdr ack", k, 0);
        send(8'h00, k); send(8'h00, k); chk("R11 prot data ack", k, 0);
        m_stop();
        byte_write(8'h10, 8'h99);
        byte_write(8'h90, 8'h66);
        model[8'h90] = 8'h66;
        set_addr(8'h10); read_hdr(); recv(1'b0, v); m_stop();
        chk("R11 low half blocked", v, model[8'h10]);
        set_addr(8'h90); read_hdr(); recv(1'b0, v); m_stop();
        chk("R11 high half written", v, 8'h66);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule